// File: doc/BRIEF.md
# Predicated Vector Immediate Copy Unit

This block takes one 32-bit instruction from the predicated wide-immediate copy group and applies it to a whole vector register in a single pass. Along with the instruction, the caller supplies the current contents of the destination vector and the governing predicate, which holds one bit for each byte of the vector. One registered cycle later the block returns the new vector, an illegal-encoding flag, and the register numbers decoded from the instruction, so that write-back logic can route the result.

Three forms are decoded. The merging integer copy places a sign-extended 8-bit immediate, optionally shifted left by eight, into every active element and leaves inactive elements untouched. The zeroing integer copy places the same kind of immediate into active elements and clears the inactive ones. The merging float copy expands an 8-bit packed float constant into half, single or double precision and places it into active elements. Elements can be 8, 16, 32 or 64 bits wide. The vector width is a parameter and defaults to 256 bits.

Top module: `vimm_copy_unit`

## Requirements
- R1: The instruction is flagged illegal when bits 31:24 differ from 8'h05, when bits 21:20 differ from 2'b01, or when bits 15:13 equal 3'b111.
- R2: An integer form (bits 15:14 = 01 merging, 00 zeroing) with element size 0 and the shift flag (bit 13) set is flagged illegal.
- R3: The float form (bits 15:13 = 110) with element size 0 is flagged illegal.
- R4: When the illegal flag is raised, the output vector is equal to the input vector.
- R5: Bits 23:22 select the element size (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). An element is active only when the predicate bit of its lowest byte is set. Predicate bits for the other bytes of the element have no effect.
- R6: In the merging integer form, each active element receives the sign-extended immediate from bits 12:5, truncated to the element width. Each inactive element keeps its input value.
- R7: In the zeroing integer form, each active element receives the immediate and each inactive element becomes zero.
- R8: When the shift flag (bit 13) of an integer form is set, the sign-extended immediate is shifted left by 8 before it is truncated.
- R9: The float immediate abcdefgh (bits 12:5) expands as follows. The sign is a. The exponent is ~b, followed by b repeated (exponent width - 3) times, followed by cd. The fraction is efgh followed by zeros. This applies to half (5/10), single (8/23) and double (11/52) precision. Active elements receive the expansion and inactive elements are kept.
- R10: out_valid equals in_valid delayed by one clock. The other outputs change only in the cycle after an in_valid cycle and otherwise hold their values. Reset clears every output to zero.
- R11: out_dst carries bits 4:0 and out_pred_sel carries bits 19:16 of the accepted instruction, with the same one-cycle timing as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| src_vec | input | VLEN_BITS | Current contents of the destination vector |
| pred | input | VLEN_BITS/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_vec | output | VLEN_BITS | Result vector |
| out_illegal | output | 1 | Instruction encoding is illegal |
| out_dst | output | 5 | Destination register number |
| out_pred_sel | output | 4 | Governing predicate register number |

## Verification
The block holds state only in its output register stage, so any wrong internal value shows up at the ports in the cycle after the instruction is accepted. A mask that reads the wrong predicate bit corrupts whole elements. A replication or float-expansion slip shows up as wrong bytes inside active elements. A decode error shows up either as a wrong illegal flag or as a vector that is no longer a copy of its input. The scoreboard compares every result against a model computed from the requirements. Idle cycles check that the outputs hold their values.

// File: rtl/vcopy_pkg.sv
package vcopy_pkg;

  typedef enum logic [1:0] {
    CP_MERGE_INT = 2'd0,
    CP_ZERO_INT  = 2'd1,
    CP_MERGE_FP  = 2'd2,
    CP_NONE      = 2'd3
  } copy_form_e;

  typedef struct packed {
    copy_form_e  form;
    logic [1:0]  esz;
    logic        illegal;
    logic [63:0] imm;
    logic [3:0]  pred_sel;
    logic [4:0]  dst;
  } copy_ctl_t;

  // Expand packed 8-bit float constant into the element format chosen by esz.
  function automatic logic [63:0] fp8_expand(input logic [1:0] esz, input logic [7:0] k);
    logic a, b;
    logic [1:0] cd;
    logic [3:0] frac4;
    a     = k[7];
    b     = k[6];
    cd    = k[5:4];
    frac4 = k[3:0];
    case (esz)
      2'd1:    fp8_expand = {48'd0, a, ~b, {2{b}}, cd, frac4, 6'd0};
      2'd2:    fp8_expand = {32'd0, a, ~b, {5{b}}, cd, frac4, 19'd0};
      2'd3:    fp8_expand = {a, ~b, {8{b}}, cd, frac4, 48'd0};
      default: fp8_expand = 64'd0;
    endcase
  endfunction

endpackage

// File: rtl/vcopy_decode.sv
module vcopy_decode
  import vcopy_pkg::*;
(
  input  logic [31:0] insn,
  output copy_ctl_t   ctl
);

  logic        group_ok;
  logic        shift_flag;
  logic [63:0] int_imm;
  copy_form_e  form;

  always_comb begin
    group_ok   = (insn[31:24] == 8'h05) && (insn[21:20] == 2'b01);
    shift_flag = insn[13];

    if (insn[15:14] == 2'b01)      form = CP_MERGE_INT;
    else if (insn[15:14] == 2'b00) form = CP_ZERO_INT;
    else if (insn[15:13] == 3'b110) form = CP_MERGE_FP;
    else                           form = CP_NONE;

    int_imm = {{56{insn[12]}}, insn[12:5]};
    if (shift_flag) int_imm = int_imm << 8;

    ctl.form     = form;
    ctl.esz      = insn[23:22];
    ctl.pred_sel = insn[19:16];
    ctl.dst      = insn[4:0];
    ctl.imm      = (form == CP_MERGE_FP) ? fp8_expand(insn[23:22], insn[12:5]) : int_imm;
    ctl.illegal  = !group_ok
                || (form == CP_NONE)
                || ((form == CP_MERGE_FP) && (insn[23:22] == 2'd0))
                || ((form != CP_MERGE_FP) && (insn[23:22] == 2'd0) && shift_flag);
  end

endmodule

// File: rtl/vcopy_lane_mask.sv
module vcopy_lane_mask #(
  parameter int NBYTES = 32
) (
  input  logic [1:0]        esz,
  input  logic [NBYTES-1:0] pred,
  output logic [NBYTES-1:0] byte_mask
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int HBASE = b & ~1;
    localparam int WBASE = b & ~3;
    localparam int DBASE = b & ~7;
    assign byte_mask[b] = (esz == 2'd0) ? pred[b]     :
                          (esz == 2'd1) ? pred[HBASE] :
                          (esz == 2'd2) ? pred[WBASE] : pred[DBASE];
  end

endmodule

// File: rtl/vcopy_replicate.sv
module vcopy_replicate #(
  parameter int NBYTES = 32
) (
  input  logic [1:0]          esz,
  input  logic [63:0]         imm,
  output logic [8*NBYTES-1:0] rep
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int HOFF = 8 * (b % 2);
    localparam int WOFF = 8 * (b % 4);
    localparam int DOFF = 8 * (b % 8);
    assign rep[8*b +: 8] = (esz == 2'd0) ? imm[7:0]      :
                           (esz == 2'd1) ? imm[HOFF +: 8] :
                           (esz == 2'd2) ? imm[WOFF +: 8] : imm[DOFF +: 8];
  end

endmodule

// File: rtl/vimm_copy_unit.sv
module vimm_copy_unit
  import vcopy_pkg::*;
#(
  parameter int VLEN_BITS = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [31:0]            insn,
  input  logic [VLEN_BITS-1:0]   src_vec,
  input  logic [VLEN_BITS/8-1:0] pred,
  output logic                   out_valid,
  output logic [VLEN_BITS-1:0]   out_vec,
  output logic                   out_illegal,
  output logic [4:0]             out_dst,
  output logic [3:0]             out_pred_sel
);

  localparam int NBYTES = VLEN_BITS / 8;

  copy_ctl_t            ctl;
  logic [NBYTES-1:0]    byte_mask;
  logic [VLEN_BITS-1:0] rep_vec;
  logic [VLEN_BITS-1:0] nxt_vec;

  vcopy_decode u_decode (
    .insn (insn),
    .ctl  (ctl)
  );

  vcopy_lane_mask #(.NBYTES(NBYTES)) u_mask (
    .esz       (ctl.esz),
    .pred      (pred),
    .byte_mask (byte_mask)
  );

  vcopy_replicate #(.NBYTES(NBYTES)) u_rep (
    .esz (ctl.esz),
    .imm (ctl.imm),
    .rep (rep_vec)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    assign nxt_vec[8*b +: 8] = ctl.illegal  ? src_vec[8*b +: 8] :
                               byte_mask[b] ? rep_vec[8*b +: 8] :
                               (ctl.form == CP_ZERO_INT) ? 8'h00 : src_vec[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_vec      <= '0;
      out_illegal  <= 1'b0;
      out_dst      <= '0;
      out_pred_sel <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec      <= nxt_vec;
        out_illegal  <= ctl.illegal;
        out_dst      <= ctl.dst;
        out_pred_sel <= ctl.pred_sel;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec) && $stable(out_illegal));
  a_r1_bad_group_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (insn[31:24] != 8'h05) |=> out_illegal);
  a_r4_illegal_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctl.illegal |=> out_illegal && (out_vec == $past(src_vec)));
  a_r7_zero_empty_pred: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ctl.illegal && (ctl.form == CP_ZERO_INT) && (pred == '0) |=> out_vec == '0);
  a_r11_dst_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dst == $past(insn[4:0]));

endmodule

// File: tb/vimm_copy_unit_bench.sv
`timescale 1ns/1ps
module vimm_copy_unit_bench;

  localparam int VB = 256;
  localparam int NB = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   insn;
  logic [VB-1:0] src_vec;
  logic [NB-1:0] pred;
  logic          out_valid;
  logic [VB-1:0] out_vec;
  logic          out_illegal;
  logic [4:0]    out_dst;
  logic [3:0]    out_pred_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [VB-1:0] q_vec[$];
  logic          q_ill[$];
  logic [8:0]    q_fld[$];
  string         q_tag[$];
  logic [VB-1:0] last_vec;

  always #2 clk = ~clk;

  vimm_copy_unit u_vimm_copy_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_vec(src_vec), .pred(pred), .out_valid(out_valid), .out_vec(out_vec),
    .out_illegal(out_illegal), .out_dst(out_dst), .out_pred_sel(out_pred_sel)
  );

  function automatic logic [31:0] mk(input logic [2:0] f, input logic [1:0] esz,
                                     input logic [3:0] pg, input logic [7:0] k,
                                     input logic [4:0] rd);
    return {8'h05, esz, 2'b01, pg, f, k, rd};
  endfunction

  task automatic ref_model(input logic [31:0] w, input logic [VB-1:0] src,
                           input logic [NB-1:0] p, output logic [VB-1:0] res,
                           output logic ill);
    logic [63:0] imm;
    logic is_fp, is_int, zero;
    int eb;
    logic [7:0] k;
    k      = w[12:5];
    eb     = 1 << w[23:22];
    is_int = (w[15:14] == 2'b01) || (w[15:14] == 2'b00);
    zero   = (w[15:14] == 2'b00);
    is_fp  = (w[15:13] == 3'b110);
    ill = (w[31:24] != 8'h05) || (w[21:20] != 2'b01) || (!is_int && !is_fp)
       || (is_fp && w[23:22] == 0) || (is_int && w[23:22] == 0 && w[13]);
    if (is_fp) begin
      case (w[23:22])
        2'd1: imm = {48'd0, k[7], ~k[6], {2{k[6]}}, k[5:4], k[3:0], 6'd0};
        2'd2: imm = {32'd0, k[7], ~k[6], {5{k[6]}}, k[5:4], k[3:0], 19'd0};
        default: imm = {k[7], ~k[6], {8{k[6]}}, k[5:4], k[3:0], 48'd0};
      endcase
    end else begin
      imm = 64'(signed'(k));
      if (w[13]) imm = imm * 256;
    end
    res = src;
    if (!ill) begin
      for (int e = 0; e < NB / eb; e++) begin
        for (int j = 0; j < eb; j++) begin
          if (p[e*eb]) res[8*(e*eb+j) +: 8] = imm[8*j +: 8];
          else if (zero) res[8*(e*eb+j) +: 8] = 8'h00;
        end
      end
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [VB-1:0] src,
                      input logic [NB-1:0] p, input string tag);
    logic [VB-1:0] r;
    logic il;
    ref_model(w, src, p, r, il);
    @(negedge clk);
    insn = w; src_vec = src; pred = p; in_valid = 1'b1;
    q_vec.push_back(r); q_ill.push_back(il);
    q_fld.push_back({w[19:16], w[4:0]}); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    insn = 32'hFFFF_FFFF;
    src_vec = {8{32'hDEAD_BEEF}};
  endtask

  task automatic check(input bit ok, input string tag, input logic [VB-1:0] act,
                       input logic [VB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear.
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      check(out_valid == in_valid, "R10 out_valid timing", VB'(out_valid), VB'(in_valid));
      if (out_valid) begin
        if (q_vec.size() == 0) begin
          check(1'b0, "R10 unexpected result", out_vec, '0);
        end else begin
          logic [VB-1:0] ev;
          logic ei;
          logic [8:0] ef;
          string t;
          ev = q_vec.pop_front(); ei = q_ill.pop_front();
          ef = q_fld.pop_front(); t = q_tag.pop_front();
          check(out_vec == ev, t, out_vec, ev);
          check(out_illegal == ei, {t, " illegal flag"}, VB'(out_illegal), VB'(ei));
          check({out_pred_sel, out_dst} == ef, "R11 register fields",
                VB'({out_pred_sel, out_dst}), VB'(ef));
        end
      end else begin
        check(out_vec == last_vec, "R10 hold while idle", out_vec, last_vec);
      end
      last_vec = out_vec;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VB-1:0] s1, s2;
    s1 = {32'h0123_4567, 32'h89AB_CDEF, 32'h1122_3344, 32'h5566_7788,
          32'h99AA_BBCC, 32'hDDEE_FF00, 32'h0F1E_2D3C, 32'h4B5A_6978};
    s2 = ~s1;
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_vec = '0; pred = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 0 && out_vec == '0 && out_illegal == 0 && out_dst == 0,
          "R10 reset state", out_vec, '0);
    last_vec = out_vec;

    send(mk(3'b010, 2'd0, 4'd3, 8'h5A, 5'd7), s1, 32'h5555_5555, "R6 merge byte");
    send(mk(3'b010, 2'd1, 4'd1, 8'hFD, 5'd2), s1, 32'h0000_FF0F, "R6 merge half neg");
    idle();
    send(mk(3'b011, 2'd2, 4'd5, 8'h81, 5'd9), s2, 32'h1111_0101, "R8 shifted word");
    send(mk(3'b001, 2'd3, 4'd0, 8'h07, 5'd31), s1, 32'h0100_0001, "R7 zero double");
    send(mk(3'b000, 2'd0, 4'd2, 8'hC3, 5'd4), s2, 32'hF0F0_0F0F, "R7 zero byte");
    send(mk(3'b001, 2'd1, 4'd8, 8'h80, 5'd5), s2, 32'h0000_0000, "R7 zero empty pred shifted half");
    send(mk(3'b010, 2'd1, 4'd6, 8'h44, 5'd6), s1, 32'hAAAA_AAAA, "R5 odd bits only half");
    send(mk(3'b010, 2'd3, 4'd6, 8'h44, 5'd6), s1, 32'hFEFE_FEFE, "R5 upper bits only double");
    send(mk(3'b010, 2'd2, 4'd6, 8'h21, 5'd6), s1, 32'h1010_1111, "R5 word mixed");
    idle(); idle();
    send(mk(3'b110, 2'd1, 4'd7, 8'h70, 5'd10), s1, 32'h3333_3333, "R9 fp half one");
    send(mk(3'b110, 2'd2, 4'd7, 8'hC5, 5'd11), s2, 32'h0F0F_F0F0, "R9 fp single");
    send(mk(3'b110, 2'd3, 4'd7, 8'h3F, 5'd12), s1, 32'h0100_0100, "R9 fp double");
    send(mk(3'b011, 2'd0, 4'd1, 8'h12, 5'd13), s1, 32'hFFFF_FFFF, "R2 byte shift illegal");
    send(mk(3'b110, 2'd0, 4'd1, 8'h70, 5'd14), s2, 32'hFFFF_FFFF, "R3 fp byte illegal");
    send({8'h04, mk(3'b010, 2'd1, 4'd1, 8'h12, 5'd15)}[31:0] | 32'h0, s1, 32'hFFFF_FFFF,
         "R4 placeholder");
    send({8'h07, mk(3'b010, 2'd1, 4'd1, 8'h12, 5'd15)[23:0]}, s1, 32'hFFFF_FFFF, "R1 bad top byte");
    send(mk(3'b010, 2'd2, 4'd1, 8'h12, 5'd16) ^ 32'h0030_0000, s2, 32'hFFFF_FFFF, "R1 bad bits 21:20");
    send(mk(3'b111, 2'd2, 4'd1, 8'h12, 5'd17), s1, 32'hFFFF_FFFF, "R1 form 111 R4 passthrough");
    idle(); idle(); idle();
    check(q_vec.size() == 0, "R10 all results delivered", VB'(q_vec.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule